// File: doc/BRIEF.md
# Load addressing multicycle core

A small multicycle processor for a 16-bit, word-addressed instruction set that executes only load-type instructions. It holds eight 16-bit general registers, a program counter and one unified memory for both code and data. Each instruction moves through a fixed sequence of states. The four supported forms use four different ways to form an address: an effective address relative to the PC with no memory access, a direct PC-relative load, a doubly indirect PC-relative load, and a register base plus a short offset. Code and data share the same memory, so a load aimed at an instruction returns that instruction's 16-bit encoding.

A test environment preloads the memory through a write port while the core is halted. It then pulses `start_i` with a start PC and a breakpoint address. The core clears all registers and runs until the PC equals the breakpoint, stopping before that instruction executes. It also stops on any unsupported opcode and raises an illegal flag. The register file can then be read through a debug select port. The memory is indexed by the low `MEM_AW` bits of every address, so wider addresses wrap onto the array.

Top module: `ldm_core`

## Requirements
- R1: After reset, `halted_o` is 1, `illegal_o` is 0, `pc_o` is 0 and all eight registers read back as zero.
- R2: A `start_i` pulse while halted loads `pc_o` with `start_pc_i`, clears all eight registers and `illegal_o`, and starts fetching on the next cycle.
- R3: Opcode 4'hE in bits 15:12 (address form) writes register bits 11:9 with PC+1 plus the sign-extended field in bits 8:0, and does not read memory.
- R4: Opcode 4'h2 (direct form) writes register bits 11:9 with the memory word at PC+1 plus the sign-extended bits 8:0.
- R5: Opcode 4'hA (indirect form) reads the word at PC+1 plus the sign-extended bits 8:0, uses that word as an address, and writes the word found there to register bits 11:9.
- R6: Opcode 4'h6 (base form) writes register bits 11:9 with the memory word at the register selected by bits 8:6 plus the sign-extended 6-bit field in bits 5:0.
- R7: Code and data share one memory: a PC-relative field of all ones addresses the instruction itself, and loading from an instruction location returns its encoding.
- R8: When the PC equals `brk_addr_i` at fetch, the core halts without executing that instruction, with `illegal_o` at 0 and `pc_o` equal to the breakpoint.
- R9: Any opcode other than 4'h2, 4'h6, 4'hA and 4'hE sets `illegal_o` and halts, with `pc_o` one past the bad instruction and no register changed.
- R10: Counted in rising edges after the one that samples `start_i`, the address form takes 4 cycles, the direct and base forms 5, the indirect form 6, an illegal opcode 2 before halt, and the breakpoint fetch 1.
- R11: Memory uses the low `MEM_AW` address bits, and preload writes are accepted only while `halted_o` is 1; a write attempted while running leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken while halted |
| start_pc_i | input | 16 | Address of the first instruction |
| brk_addr_i | input | 16 | Breakpoint address; the core stops before it |
| load_we_i | input | 1 | Preload write enable |
| load_addr_i | input | 16 | Preload word address |
| load_data_i | input | 16 | Preload word |
| dbg_sel_i | input | 3 | Register select for readout |
| dbg_data_o | output | 16 | Selected register value |
| pc_o | output | 16 | Current program counter |
| halted_o | output | 1 | Core is halted |
| illegal_o | output | 1 | Halt was caused by an unsupported opcode |

## Verification
The assertions check the control sequence on every cycle: the PC step at each non-breakpoint fetch, the stop on a breakpoint match, the frozen PC while halted, the state after a start pulse, the address form skipping memory, and the indirect form taking its second read. Only the bench scenarios can show the data results. These are the register values produced by each addressing mode across all destinations and offset extremes, self-loads of instruction encodings, address wrap, and the ignored preload write during a run. The bench compares them with an instruction-level model and also measures the exact cycle count of each run.

// File: rtl/ldm_pkg.sv
`timescale 1ns/1ps
package ldm_pkg;
  localparam int unsigned XLEN = 16;
  localparam int unsigned NREG = 8;
  localparam int unsigned RIW  = $clog2(NREG);

  typedef logic [XLEN-1:0] word_t;

  localparam logic [3:0] OPC_LD  = 4'h2;
  localparam logic [3:0] OPC_LDR = 4'h6;
  localparam logic [3:0] OPC_LDI = 4'hA;
  localparam logic [3:0] OPC_LEA = 4'hE;

  typedef enum logic [2:0] {
    S_HALT, S_FETCH, S_DECODE, S_ADDR, S_MEM1, S_MEM2, S_WB
  } state_e;

  function automatic logic op_legal(input logic [3:0] op);
    return (op == OPC_LD) || (op == OPC_LDR) || (op == OPC_LDI) || (op == OPC_LEA);
  endfunction
endpackage

// File: rtl/ldm_mem.sv
`timescale 1ns/1ps
module ldm_mem
  import ldm_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic  clk_i,
  input  logic  we_i,
  input  word_t waddr_i,
  input  word_t wdata_i,
  input  word_t raddr_i,
  output word_t rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  word_t mem_q [DEPTH];

  // only low address bits index the array; upper bits wrap
  logic unused_hi;
  assign unused_hi = ^{waddr_i[XLEN-1:AW], raddr_i[XLEN-1:AW]};

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i[AW-1:0]] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i[AW-1:0]];
endmodule

// File: rtl/ldm_regfile.sv
`timescale 1ns/1ps
module ldm_regfile
  import ldm_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           we_i,
  input  logic [RIW-1:0] waddr_i,
  input  word_t          wdata_i,
  input  logic [RIW-1:0] base_sel_i,
  output word_t          base_o,
  input  logic [RIW-1:0] dbg_sel_i,
  output word_t          dbg_o
);
  word_t regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign base_o = regs_q[base_sel_i];
  assign dbg_o  = regs_q[dbg_sel_i];
endmodule

// File: rtl/ldm_decode.sv
`timescale 1ns/1ps
module ldm_decode
  import ldm_pkg::*;
(
  input  word_t          ir_i,
  input  word_t          pc_i,
  input  word_t          base_val_i,
  output logic [3:0]     op_o,
  output logic           legal_o,
  output logic [RIW-1:0] dst_o,
  output logic [RIW-1:0] base_sel_o,
  output word_t          ea_o
);
  word_t off9, off6;

  assign op_o       = ir_i[15:12];
  assign legal_o    = op_legal(op_o);
  assign dst_o      = ir_i[11:9];
  assign base_sel_o = ir_i[8:6];
  assign off9       = {{(XLEN-9){ir_i[8]}}, ir_i[8:0]};
  assign off6       = {{(XLEN-6){ir_i[5]}}, ir_i[5:0]};

  // pc_i is already incremented past the instruction
  always_comb begin
    if (op_o == OPC_LDR) ea_o = base_val_i + off6;
    else                 ea_o = pc_i + off9;
  end
endmodule

// File: rtl/ldm_core.sv
`timescale 1ns/1ps
module ldm_core
  import ldm_pkg::*;
#(
  parameter int unsigned MEM_AW = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] start_pc_i,
  input  logic [15:0] brk_addr_i,
  input  logic        load_we_i,
  input  logic [15:0] load_addr_i,
  input  logic [15:0] load_data_i,
  input  logic [2:0]  dbg_sel_i,
  output logic [15:0] dbg_data_o,
  output logic [15:0] pc_o,
  output logic        halted_o,
  output logic        illegal_o
);
  state_e state_q;
  word_t  pc_q, ir_q, ea_q, mdr_q;
  logic   illegal_q;

  word_t          mem_raddr, mem_rdata;
  word_t          base_val, dec_ea;
  logic [3:0]     op;
  logic           legal;
  logic [RIW-1:0] dst, base_sel;
  logic           run_start;

  assign halted_o   = (state_q == S_HALT);
  assign illegal_o  = illegal_q;
  assign pc_o       = pc_q;
  assign run_start  = halted_o && start_i;

  // single read port shared by fetch and both data reads
  always_comb begin
    unique case (state_q)
      S_MEM1:  mem_raddr = ea_q;
      S_MEM2:  mem_raddr = mdr_q;
      default: mem_raddr = pc_q;
    endcase
  end

  ldm_mem #(.AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (load_we_i && halted_o),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  ldm_regfile u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (run_start),
    .we_i       (state_q == S_WB),
    .waddr_i    (dst),
    .wdata_i    (mdr_q),
    .base_sel_i (base_sel),
    .base_o     (base_val),
    .dbg_sel_i  (dbg_sel_i),
    .dbg_o      (dbg_data_o)
  );

  ldm_decode u_dec (
    .ir_i       (ir_q),
    .pc_i       (pc_q),
    .base_val_i (base_val),
    .op_o       (op),
    .legal_o    (legal),
    .dst_o      (dst),
    .base_sel_o (base_sel),
    .ea_o       (dec_ea)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_HALT;
      pc_q      <= '0;
      ir_q      <= '0;
      ea_q      <= '0;
      mdr_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_HALT: begin
          if (start_i) begin
            pc_q      <= start_pc_i;
            illegal_q <= 1'b0;
            state_q   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (pc_q == brk_addr_i) begin
            state_q <= S_HALT;
          end else begin
            ir_q    <= mem_rdata;
            pc_q    <= pc_q + 1'b1;
            state_q <= S_DECODE;
          end
        end
        S_DECODE: begin
          if (!legal) begin
            illegal_q <= 1'b1;
            state_q   <= S_HALT;
          end else begin
            state_q <= S_ADDR;
          end
        end
        S_ADDR: begin
          ea_q <= dec_ea;
          if (op == OPC_LEA) begin
            mdr_q   <= dec_ea;
            state_q <= S_WB;
          end else begin
            state_q <= S_MEM1;
          end
        end
        S_MEM1: begin
          mdr_q   <= mem_rdata;
          state_q <= (op == OPC_LDI) ? S_MEM2 : S_WB;
        end
        S_MEM2: begin
          mdr_q   <= mem_rdata;
          state_q <= S_WB;
        end
        S_WB:    state_q <= S_FETCH;
        default: state_q <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/ldm_core_chk.sv
`timescale 1ns/1ps
module ldm_core_chk
  import ldm_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] start_pc_i,
  input logic [15:0] brk_addr_i,
  input logic [15:0] pc_o,
  input logic        halted_o,
  input logic        illegal_o,
  input state_e      state_i,
  input logic [3:0]  op_i
);
  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && start_i |=> state_i == S_FETCH && !illegal_o && pc_o == $past(start_pc_i));

  p_lea_skips_mem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_ADDR && op_i == OPC_LEA |=> state_i == S_WB);

  p_ldi_second_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_MEM1 && op_i == OPC_LDI |=> state_i == S_MEM2);

  p_single_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_MEM1 && op_i != OPC_LDI |=> state_i == S_WB);

  p_brk_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH && pc_o == brk_addr_i |=> halted_o && !illegal_o && $stable(pc_o));

  p_halt_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !start_i |=> halted_o && $stable(pc_o) && $stable(illegal_o));

  p_illegal_halts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(illegal_o) |-> halted_o && $past(state_i) == S_DECODE);

  p_fetch_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH && pc_o != brk_addr_i |=> state_i == S_DECODE && pc_o == $past(pc_o) + 16'd1);
endmodule

bind ldm_core ldm_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .start_pc_i (start_pc_i),
  .brk_addr_i (brk_addr_i),
  .pc_o       (pc_o),
  .halted_o   (halted_o),
  .illegal_o  (illegal_o),
  .state_i    (state_q),
  .op_i       (op)
);

// File: tb/ldm_core_tb_top.sv
`timescale 1ns/1ps
module ldm_core_tb_top;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] start_pc_i = '0;
  logic [15:0] brk_addr_i = '0;
  logic        load_we_i = 1'b0;
  logic [15:0] load_addr_i = '0;
  logic [15:0] load_data_i = '0;
  logic [2:0]  dbg_sel_i = '0;
  logic [15:0] dbg_data_o, pc_o;
  logic        halted_o, illegal_o;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  logic [15:0] mdl_mem [DEPTH];
  logic [15:0] mdl_reg [8];

  always #2.5 clk_i = ~clk_i;

  ldm_core #(.MEM_AW(AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_pc_i(start_pc_i),
    .brk_addr_i(brk_addr_i), .load_we_i(load_we_i), .load_addr_i(load_addr_i),
    .load_data_i(load_data_i), .dbg_sel_i(dbg_sel_i), .dbg_data_o(dbg_data_o),
    .pc_o(pc_o), .halted_o(halted_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mrd(input logic [15:0] a);
    return mdl_mem[a[AW-1:0]];
  endfunction

  task automatic mem_put(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk_i);
    load_we_i = 1'b1; load_addr_i = a; load_data_i = d;
    @(negedge clk_i);
    load_we_i = 1'b0;
    mdl_mem[a[AW-1:0]] = d;
  endtask

  // instruction-level model of the requirements
  task automatic mdl_run(input logic [15:0] sp, input logic [15:0] brk,
                         output bit ill, output logic [15:0] pc_end, output int cyc);
    logic [15:0] pc, ir, p9, b6;
    bit stop;
    pc = sp; cyc = 0; ill = 0; stop = 0;
    for (int r = 0; r < 8; r++) mdl_reg[r] = '0;
    for (int s = 0; s < 64 && !stop; s++) begin
      if (pc == brk) begin
        cyc += 1; stop = 1;
      end else begin
        ir = mrd(pc);
        pc = pc + 16'd1;
        p9 = pc + {{7{ir[8]}}, ir[8:0]};
        b6 = mdl_reg[ir[8:6]] + {{10{ir[5]}}, ir[5:0]};
        case (ir[15:12])
          4'hE: begin mdl_reg[ir[11:9]] = p9; cyc += 4; end
          4'h2: begin mdl_reg[ir[11:9]] = mrd(p9); cyc += 5; end
          4'hA: begin mdl_reg[ir[11:9]] = mrd(mrd(p9)); cyc += 6; end
          4'h6: begin mdl_reg[ir[11:9]] = mrd(b6); cyc += 5; end
          default: begin ill = 1; cyc += 2; stop = 1; end
        endcase
      end
    end
    pc_end = pc;
  endtask

  task automatic run_chk(input logic [15:0] sp, input logic [15:0] brk, input string rtag,
                         input bit poke, input logic [15:0] paddr, input logic [15:0] pdata);
    bit ill; logic [15:0] pce; int cyc; int n;
    mdl_run(sp, brk, ill, pce, cyc);
    @(negedge clk_i);
    start_pc_i = sp; brk_addr_i = brk; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      load_we_i = 1'b1; load_addr_i = paddr; load_data_i = pdata;
    end
    n = 0;
    do begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      load_we_i = 1'b0;
    end while (!halted_o && n < 300);
    chk("R10", "cycles", n, cyc);
    chk("R8", "halted", halted_o, 1'b1);
    chk("R9", "illegal", illegal_o, ill);
    chk(ill ? "R9" : "R8", "pc", pc_o, pce);
    for (int r = 0; r < 8; r++) begin
      dbg_sel_i = r[2:0];
      #0.5;
      chk(rtag, $sformatf("reg%0d", r), dbg_data_o, mdl_reg[r]);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'hE: return "R3";
      4'h2: return "R4";
      4'hA: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #950000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [3:0]  ops [4];
    logic [8:0]  o9 [4];
    logic [5:0]  o6 [4];
    logic [15:0] p;
    int run;
    ops[0] = 4'hE; ops[1] = 4'h2; ops[2] = 4'hA; ops[3] = 4'h6;
    o9[0] = 9'h000; o9[1] = 9'h1FF; o9[2] = 9'h0FF; o9[3] = 9'h100;
    o6[0] = 6'h00;  o6[1] = 6'h3F;  o6[2] = 6'h1F;  o6[3] = 6'h20;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "halted", halted_o, 1'b1);
    chk("R1", "illegal", illegal_o, 1'b0);
    chk("R1", "pc", pc_o, 16'h0000);
    for (int r = 0; r < 8; r++) begin
      dbg_sel_i = r[2:0];
      #0.5;
      chk("R1", $sformatf("reg%0d", r), dbg_data_o, 16'h0000);
    end

    for (int i = 0; i < DEPTH; i++) mem_put(i[15:0], (i[15:0] * 16'h9E37) ^ 16'h3C00);

    // R7 self-referencing program; high address bits wrap onto the array (R11)
    mem_put(16'hA400, {4'hE, 3'd0, 9'h1FF});
    mem_put(16'hA401, {4'h2, 3'd1, 9'h1FF});
    mem_put(16'hA402, {4'hA, 3'd2, 9'h001});
    mem_put(16'hA403, {4'h6, 3'd3, 3'd0, 6'h02});
    mem_put(16'hA404, 16'hA400);
    run_chk(16'hA400, 16'hA404, "R7", 0, 0, 0);
    dbg_sel_i = 3'd1; #0.5; chk("R7", "self word", dbg_data_o, 16'h23FF);
    dbg_sel_i = 3'd2; #0.5; chk("R7", "indirect word", dbg_data_o, 16'hE1FF);
    dbg_sel_i = 3'd3; #0.5; chk("R7", "base word", dbg_data_o, 16'hA401);

    // R2 registers nonzero from above; a breakpoint at start clears them and runs nothing
    run_chk(16'h0123, 16'h0123, "R2", 0, 0, 0);

    // sweep of modes, destinations and offset extremes
    run = 0;
    for (int oi = 0; oi < 4; oi++) begin
      for (int d = 0; d < 8; d++) begin
        for (int k = 0; k < 4; k++) begin
          p = 16'h2000 + 16'(run * 3);
          if (ops[oi] != 4'h6) begin
            mem_put(p, {ops[oi], d[2:0], o9[k]});
            run_chk(p, p + 16'd1, op_tag(ops[oi]), 0, 0, 0);
          end else begin
            mem_put(p, {4'hE, 3'((d + 3) % 8), o9[k]});
            mem_put(p + 16'd1, {4'h6, d[2:0], 3'((d + 3) % 8), o6[k]});
            run_chk(p, p + 16'd2, "R6", 0, 0, 0);
          end
          run++;
        end
      end
    end
    // R6 base register equals destination
    mem_put(16'h0500, {4'hE, 3'd4, 9'h010});
    mem_put(16'h0501, {4'h6, 3'd4, 3'd4, 6'h3E});
    run_chk(16'h0500, 16'h0502, "R6", 0, 0, 0);

    // R9 every unsupported opcode
    for (int o = 0; o < 16; o++) begin
      if (o != 2 && o != 6 && o != 10 && o != 14) begin
        p = 16'h3000 + 16'(o * 4);
        mem_put(p, {o[3:0], 12'h5A5});
        run_chk(p, p + 16'd5, "R9", 0, 0, 0);
      end
    end
    // R9 illegal after a legal load keeps earlier result
    mem_put(16'h0600, {4'hE, 3'd5, 9'h007});
    mem_put(16'h0601, 16'h0000);
    run_chk(16'h0600, 16'h060A, "R9", 0, 0, 0);

    // R11 preload write during a run is ignored
    mem_put(16'h0305, 16'h1234);
    mem_put(16'h0300, {4'h2, 3'd4, 9'h004});
    run_chk(16'h0300, 16'h0301, "R11", 1, 16'h0305, 16'hDEAD);
    run_chk(16'h0300, 16'h0301, "R11", 0, 0, 0);
    dbg_sel_i = 3'd4; #0.5; chk("R11", "unchanged word", dbg_data_o, 16'h1234);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule